// File: doc/BRIEF.md
# NH Multi-Pass Universal Hash Engine

This block computes an NH-style almost-universal hash of a message against a key stream. Message and key data arrive as 128-bit strides on two valid/ready channels. A `start_i` pulse opens a hash. The block first takes three key strides into a sliding key window. After that, every message stride is consumed together with one new key stride. Four passes run side by side on the same message stride, and each pass uses the key advanced by one more stride than the pass before it.

In each pass the engine adds message words to key words modulo 2^32. It pairs the sums into two widening 32x32 products and adds those products into 64-bit partial accumulators. When the beat marked last has gone through, the two partials of each pass are added together. The four 64-bit pass sums then appear together as one 256-bit result, flagged by a one-cycle valid pulse. The message channel can also carry a data-less beat. With last set, this beat closes a hash without using any key, which makes an empty message possible. The engine handles one stride per clock.

Top module: `nh_hash_core`

## Requirements
- R1: Word w of a 128-bit stride (message or key) is bits [32w+31:32w]. The sum of pass p is placed at bits [64p+63:64p] of `res_data_o`.
- R2: For every stride, each message word is added to the key word with the same index, modulo 2^32. Sum 0 is then multiplied by sum 2, and sum 1 by sum 3, each as a full unsigned 64-bit product.
- R3: Products are accumulated modulo 2^64 in two partials per pass. A pass result is the modulo-2^64 sum of its two partials.
- R4: Message stride j (counting from 0) is combined in pass p with key stride j+p, where key strides are counted from the first key accepted after start.
- R5: After `start_i`, `key_ready_o` is high and `msg_ready_o` stays low until three key strides have been accepted.
- R6: Once the window is loaded, a data beat is accepted only together with one key stride in the same cycle. `msg_ready_o` for a data beat requires `key_valid_i`.
- R7: `res_valid_o` is a single-cycle pulse. It rises after the second rising edge that follows the edge accepting the last beat, unless a start comes in between.
- R8: A beat with `msg_nodata_i`=1 and `msg_last_i`=1 ends the hash without taking a key. If no data stride was accepted, the result is all zeros.
- R9: A beat with `msg_nodata_i`=1 and `msg_last_i`=0 is accepted and has no effect on the result or on key consumption. `key_ready_o` is low during such a beat.
- R10: `start_i` has priority. Both readies are low while it is high. It clears all accumulators, discards any stride or result in flight, and restarts the preload.
- R11: After the last beat is accepted, `msg_ready_o` stays low until the next start. `res_data_o` holds its value whenever `res_valid_o` is low.
- R12: After reset, both readies and `res_valid_o` are low and `res_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin (or restart) a hash |
| key_valid_i | input | 1 | Key stride valid |
| key_ready_o | output | 1 | Key stride accepted this cycle when valid |
| key_data_i | input | 128 | Key stride, word w at bits [32w+31:32w] |
| msg_valid_i | input | 1 | Message beat valid |
| msg_ready_o | output | 1 | Message beat accepted this cycle when valid |
| msg_data_i | input | 128 | Message stride, word w at bits [32w+31:32w] |
| msg_last_i | input | 1 | Beat closes the hash |
| msg_nodata_i | input | 1 | Beat carries no stride |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 256 | Four 64-bit pass sums, pass p at [64p+63:64p] |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that message readiness is withheld until three keys have been taken, that data beats and key strides fire together, that data-less beats leave the key channel alone, that start holds both readies low, that the result strobe comes at its fixed latency and lasts one cycle, and that the result holds between strobes. The arithmetic itself can only be shown by the bench's scenarios. These compare results against an independent model of the pass, window and pairing rules, using random keys, lengths from one to sixty-four strides, maximum-carry operands, empty messages, interleaved data-less beats and aborts at several points.

// File: rtl/nh_pkg.sv
package nh_pkg;
  parameter int NH_WORD_W = 32;
  parameter int NH_WORDS  = 4;
  parameter int NH_PASSES = 4;

  typedef enum logic [1:0] {
    NH_IDLE = 2'd0,
    NH_LOAD = 2'd1,
    NH_RUN  = 2'd2
  } nh_state_e;
endpackage

// File: rtl/nh_key_window.sv
module nh_key_window #(
  parameter int STRIDE_W = 128,
  parameter int PASSES   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         shift_i,
  input  logic [STRIDE_W-1:0]          key_i,
  output logic [PASSES*STRIDE_W-1:0]   taps_o
);
  localparam int DEPTH = (PASSES > 1) ? PASSES - 1 : 1;

  logic [STRIDE_W-1:0] slot_q [DEPTH];

  // Oldest key sits in slot 0; the live input is the newest tap.
  generate
    if (PASSES > 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (shift_i) begin
          for (int i = 0; i < DEPTH - 1; i++) slot_q[i] <= slot_q[i+1];
          slot_q[DEPTH-1] <= key_i;
        end
      end
      for (genvar p = 0; p < PASSES - 1; p++) begin : g_tap
        assign taps_o[p*STRIDE_W +: STRIDE_W] = slot_q[p];
      end
    end else begin : g_noshift
      always_ff @(posedge clk) slot_q[0] <= '0;
    end
  endgenerate

  assign taps_o[(PASSES-1)*STRIDE_W +: STRIDE_W] = key_i;
endmodule

// File: rtl/nh_pass_mac.sv
module nh_pass_mac #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              en_i,
  input  logic [WORD_W*WORDS-1:0]           msg_i,
  input  logic [WORD_W*WORDS-1:0]           key_i,
  output logic [(WORDS/2)*2*WORD_W-1:0]     prod_o
);
  localparam int HALF   = WORDS / 2;
  localparam int PROD_W = 2 * WORD_W;

  logic [WORD_W-1:0] sum_w [WORDS];
  logic [HALF*PROD_W-1:0] prod_d, prod_q;

  always_comb begin
    for (int w = 0; w < WORDS; w++)
      sum_w[w] = msg_i[w*WORD_W +: WORD_W] + key_i[w*WORD_W +: WORD_W];
    for (int h = 0; h < HALF; h++)
      prod_d[h*PROD_W +: PROD_W] = PROD_W'(sum_w[h]) * PROD_W'(sum_w[h+HALF]);
  end

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else if (en_i) prod_q <= prod_d;
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/nh_accum.sv
module nh_accum #(
  parameter int PASSES = 4,
  parameter int HALF   = 2,
  parameter int ACC_W  = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr_i,
  input  logic                        add_i,
  input  logic [PASSES*HALF*ACC_W-1:0] prod_i,
  output logic [PASSES*ACC_W-1:0]     fold_o
);
  localparam int LANES = PASSES * HALF;

  logic [ACC_W-1:0] acc_q [LANES];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      for (int l = 0; l < LANES; l++) acc_q[l] <= '0;
    end else if (add_i) begin
      for (int l = 0; l < LANES; l++)
        acc_q[l] <= acc_q[l] + prod_i[l*ACC_W +: ACC_W];
    end
  end

  always_comb begin
    for (int p = 0; p < PASSES; p++) begin
      logic [ACC_W-1:0] t;
      t = '0;
      for (int h = 0; h < HALF; h++) t = t + acc_q[p*HALF + h];
      fold_o[p*ACC_W +: ACC_W] = t;
    end
  end
endmodule

// File: rtl/nh_hash_core.sv
module nh_hash_core
  import nh_pkg::*;
#(
  parameter int WORD_W = NH_WORD_W,
  parameter int WORDS  = NH_WORDS,
  parameter int PASSES = NH_PASSES
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic                          key_valid_i,
  output logic                          key_ready_o,
  input  logic [WORD_W*WORDS-1:0]       key_data_i,
  input  logic                          msg_valid_i,
  output logic                          msg_ready_o,
  input  logic [WORD_W*WORDS-1:0]       msg_data_i,
  input  logic                          msg_last_i,
  input  logic                          msg_nodata_i,
  output logic                          res_valid_o,
  output logic [PASSES*2*WORD_W-1:0]    res_data_o
);
  localparam int STRIDE_W = WORD_W * WORDS;
  localparam int HALF     = WORDS / 2;
  localparam int ACC_W    = 2 * WORD_W;
  localparam int RES_W    = PASSES * ACC_W;
  localparam int CNT_W    = $clog2(PASSES + 1);

  nh_state_e st_q;
  logic [CNT_W-1:0] load_cnt_q;

  logic key_fire, data_fire, last_fire;
  logic s1_add_q, s1_last_q, fin_q;
  logic [PASSES*STRIDE_W-1:0] taps;
  logic [PASSES*HALF*ACC_W-1:0] prods;
  logic [RES_W-1:0] fold;
  logic res_valid_q;
  logic [RES_W-1:0] res_data_q;

  // Handshake decode
  always_comb begin
    key_ready_o = 1'b0;
    msg_ready_o = 1'b0;
    if (!start_i) begin
      if (st_q == NH_LOAD) key_ready_o = 1'b1;
      if (st_q == NH_RUN) begin
        key_ready_o = msg_valid_i && !msg_nodata_i;
        msg_ready_o = msg_nodata_i || key_valid_i;
      end
    end
  end

  assign key_fire  = key_valid_i && key_ready_o;
  assign data_fire = msg_valid_i && msg_ready_o && !msg_nodata_i;
  assign last_fire = msg_valid_i && msg_ready_o && msg_last_i;

  // Sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= NH_IDLE;
      load_cnt_q <= '0;
    end else if (start_i) begin
      st_q       <= (PASSES > 1) ? NH_LOAD : NH_RUN;
      load_cnt_q <= '0;
    end else begin
      case (st_q)
        NH_LOAD: if (key_fire) begin
          load_cnt_q <= load_cnt_q + 1'b1;
          if (load_cnt_q == CNT_W'(PASSES - 2)) st_q <= NH_RUN;
        end
        NH_RUN:  if (last_fire) st_q <= NH_IDLE;
        default: st_q <= st_q;
      endcase
    end
  end

  nh_key_window #(.STRIDE_W(STRIDE_W), .PASSES(PASSES)) u_win (
    .clk    (clk),
    .rst    (rst),
    .shift_i(key_fire),
    .key_i  (key_data_i),
    .taps_o (taps)
  );

  generate
    for (genvar p = 0; p < PASSES; p++) begin : g_pass
      nh_pass_mac #(.WORD_W(WORD_W), .WORDS(WORDS)) u_mac (
        .clk   (clk),
        .rst   (rst),
        .en_i  (data_fire),
        .msg_i (msg_data_i),
        .key_i (taps[p*STRIDE_W +: STRIDE_W]),
        .prod_o(prods[p*HALF*ACC_W +: HALF*ACC_W])
      );
    end
  endgenerate

  // Pipeline flags following the product registers
  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      s1_add_q  <= 1'b0;
      s1_last_q <= 1'b0;
      fin_q     <= 1'b0;
    end else begin
      s1_add_q  <= data_fire;
      s1_last_q <= last_fire;
      fin_q     <= s1_last_q;
    end
  end

  nh_accum #(.PASSES(PASSES), .HALF(HALF), .ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clr_i (start_i),
    .add_i (s1_add_q),
    .prod_i(prods),
    .fold_o(fold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_q <= 1'b0;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= fin_q && !start_i;
      if (fin_q && !start_i) res_data_q <= fold;
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_data_o  = res_data_q;
endmodule

// File: rtl/nh_hash_core_chk.sv
module nh_hash_core_chk #(
  parameter int PASSES = 4,
  parameter int RES_W  = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             key_valid_i,
  input logic             key_ready_o,
  input logic             msg_valid_i,
  input logic             msg_ready_o,
  input logic             msg_last_i,
  input logic             msg_nodata_i,
  input logic             res_valid_o,
  input logic [RES_W-1:0] res_data_o
);
  logic [7:0] keys_seen;
  logic kf, df, lf, nf;

  assign kf = key_valid_i && key_ready_o;
  assign df = msg_valid_i && msg_ready_o && !msg_nodata_i;
  assign lf = msg_valid_i && msg_ready_o && msg_last_i;
  assign nf = msg_valid_i && msg_ready_o && msg_nodata_i;

  always_ff @(posedge clk) begin
    if (rst || start_i) keys_seen <= '0;
    else if (kf && keys_seen < 8'(PASSES - 1)) keys_seen <= keys_seen + 8'd1;
  end

  // R5: message side held off until the window is loaded
  p_preload_r5: assert property (@(posedge clk) disable iff (rst)
    msg_ready_o |-> keys_seen >= 8'(PASSES - 1));

  // R6: a data stride always pairs with a key stride
  p_key_pair_r6: assert property (@(posedge clk) disable iff (rst)
    df |-> kf);

  // R8 / R9: data-less beats leave the key channel alone
  p_nodata_key_r9: assert property (@(posedge clk) disable iff (rst)
    nf |-> !key_ready_o);

  // R10: start owns the cycle
  p_start_prio_r10: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (!msg_ready_o && !key_ready_o));

  // R7: fixed result latency
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    lf ##1 !start_i ##1 !start_i |=> res_valid_o);

  // R7: strobe lasts one cycle
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |=> !res_valid_o);

  // R11: no beats after the closing beat
  p_closed_r11: assert property (@(posedge clk) disable iff (rst)
    lf |=> !msg_ready_o);

  // R11: result held between strobes
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !res_valid_o |-> $stable(res_data_o));
endmodule

bind nh_hash_core nh_hash_core_chk #(
  .PASSES(PASSES),
  .RES_W (PASSES*2*WORD_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .key_valid_i (key_valid_i),
  .key_ready_o (key_ready_o),
  .msg_valid_i (msg_valid_i),
  .msg_ready_o (msg_ready_o),
  .msg_last_i  (msg_last_i),
  .msg_nodata_i(msg_nodata_i),
  .res_valid_o (res_valid_o),
  .res_data_o  (res_data_o)
);

// File: tb/nh_hash_core_tb_top.sv
`timescale 1ns/1ps
module nh_hash_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic key_valid_i = 1'b0, key_ready_o;
  logic [127:0] key_data_i = '0;
  logic msg_valid_i = 1'b0, msg_ready_o;
  logic [127:0] msg_data_i = '0;
  logic msg_last_i = 1'b0, msg_nodata_i = 1'b0;
  logic res_valid_o;
  logic [255:0] res_data_o;

  always #2 clk = ~clk;

  nh_hash_core dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .key_valid_i(key_valid_i), .key_ready_o(key_ready_o), .key_data_i(key_data_i),
    .msg_valid_i(msg_valid_i), .msg_ready_o(msg_ready_o), .msg_data_i(msg_data_i),
    .msg_last_i(msg_last_i), .msg_nodata_i(msg_nodata_i),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [127:0] msg_mem [64];
  logic [127:0] key_mem [67];
  logic [255:0] exp_q [$];
  logic [255:0] last_res = '0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] nh_model(input int n);
    logic [255:0] r;
    r = '0;
    for (int p = 0; p < 4; p++) begin
      logic [63:0] acc;
      acc = '0;
      for (int j = 0; j < n; j++) begin
        for (int h = 0; h < 2; h++) begin
          logic [31:0] a, b;
          a = msg_mem[j][32*h +: 32] + key_mem[j+p][32*h +: 32];
          b = msg_mem[j][32*(h+2) +: 32] + key_mem[j+p][32*(h+2) +: 32];
          acc = acc + ({32'd0, a} * {32'd0, b});
        end
      end
      r[64*p +: 64] = acc;
    end
    return r;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 64; i++)
      msg_mem[i] = {$urandom(), $urandom(), $urandom(), $urandom()};
    for (int i = 0; i < 67; i++)
      key_mem[i] = {$urandom(), $urandom(), $urandom(), $urandom()};
  endtask

  task automatic wait_msg();
    #0.5;
    while (!msg_ready_o) begin @(posedge clk); #0.5; end
    @(posedge clk);
  endtask

  task automatic clear_inputs();
    key_valid_i = 0; msg_valid_i = 0; msg_last_i = 0; msg_nodata_i = 0;
  endtask

  // Drives one hash; pushes the expected result when its closing beat is taken.
  task automatic run_hash(input int n, input bit mid_gap, input bit end_gap,
                          input bit chk_pre, input bit chk_lat, input bit abort_last,
                          input bit no_last, input bit use_ovr, input logic [255:0] ovr);
    logic [255:0] exp;
    exp = use_ovr ? ovr : nh_model(n);
    @(negedge clk);
    clear_inputs();
    start_i = 1;
    #0.5;
    if (chk_pre) chk(!msg_ready_o && !key_ready_o, "R10 readies during start",
                     {254'd0, msg_ready_o, key_ready_o}, '0);
    @(posedge clk);
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < 3; i++) begin
      if (i > 0) @(negedge clk);
      key_valid_i = 1; key_data_i = key_mem[i];
      msg_valid_i = chk_pre; msg_data_i = '1;
      #0.5;
      if (chk_pre) chk(!msg_ready_o, "R5 msg held during preload", {255'd0, msg_ready_o}, '0);
      while (!key_ready_o) begin @(posedge clk); #0.5; end
      @(posedge clk);
    end
    for (int j = 0; j < n; j++) begin
      if (mid_gap && j == n / 2) begin
        @(negedge clk);
        msg_valid_i = 1; msg_nodata_i = 1; msg_last_i = 0; msg_data_i = '1;
        key_valid_i = 1; key_data_i = ~key_mem[j+3];
        #0.5;
        chk(!key_ready_o, "R9 no key taken on data-less beat", {255'd0, key_ready_o}, '0);
        wait_msg();
      end
      @(negedge clk);
      msg_valid_i = 1; msg_nodata_i = 0; msg_data_i = msg_mem[j];
      msg_last_i = (j == n - 1) && !end_gap && !no_last;
      key_valid_i = 1; key_data_i = key_mem[j+3];
      wait_msg();
    end
    if (!no_last && (end_gap || n == 0)) begin
      @(negedge clk);
      msg_valid_i = 1; msg_nodata_i = 1; msg_last_i = 1; key_valid_i = 0;
      #0.5;
      chk(!key_ready_o, "R8 closing data-less beat takes no key", {255'd0, key_ready_o}, '0);
      wait_msg();
    end
    if (!no_last && !abort_last) exp_q.push_back(exp);
    @(negedge clk);
    clear_inputs();
    if (abort_last) begin
      start_i = 1;
      @(posedge clk);
      @(negedge clk);
      start_i = 0;
    end else if (chk_lat) begin
      chk(res_valid_o == 0, "R7 no strobe one edge after last", {255'd0, res_valid_o}, '0);
      @(negedge clk);
      chk(res_valid_o == 0, "R7 no strobe two edges... first", {255'd0, res_valid_o}, '0);
      @(negedge clk);
      chk(res_valid_o == 1, "R7 strobe after second edge", {255'd0, res_valid_o}, 256'd1);
      @(negedge clk);
      chk(res_valid_o == 0, "R7 strobe is one cycle", {255'd0, res_valid_o}, '0);
    end
    repeat (4) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected result", res_data_o, '0);
      end else begin
        logic [255:0] e;
        e = exp_q.pop_front();
        chk(res_data_o === e, "R1 R2 R3 R4 result", res_data_o, e);
      end
      last_res = res_data_o;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] ovr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!key_ready_o && !msg_ready_o, "R12 readies low in reset",
        {254'd0, key_ready_o, msg_ready_o}, '0);
    rst = 0;
    @(negedge clk);
    chk(res_valid_o == 0, "R12 no strobe after reset", {255'd0, res_valid_o}, '0);
    chk(res_data_o == '0, "R12 result zero after reset", res_data_o, '0);
    chk(!msg_ready_o && !key_ready_o, "R12 idle before start",
        {254'd0, key_ready_o, msg_ready_o}, '0);

    // R1 R4 directed: keys differ per stride in word 0 only
    for (int i = 0; i < 67; i++) key_mem[i] = {96'd0, 32'(i)};
    msg_mem[0] = {32'd7, 32'd3, 32'd5, 32'd2};
    ovr = {64'd50, 64'd47, 64'd44, 64'd41};
    run_hash(1, 0, 0, 1, 1, 0, 0, 1, ovr);

    // Random lengths and content
    fill_random(); run_hash(1, 0, 0, 0, 1, 0, 0, 0, '0);
    fill_random(); run_hash(4, 0, 0, 1, 0, 0, 0, 0, '0);
    fill_random(); run_hash(64, 0, 0, 0, 1, 0, 0, 0, '0);
    for (int t = 0; t < 4; t++) begin
      fill_random();
      run_hash(int'($urandom_range(1, 64)), 0, 0, 0, 0, 0, 0, 0, '0);
    end

    // R2 R3 maximum carry: every sum is all ones
    for (int i = 0; i < 64; i++) msg_mem[i] = '1;
    for (int i = 0; i < 67; i++) key_mem[i] = '0;
    run_hash(64, 0, 0, 0, 0, 0, 0, 0, '0);

    // R8 empty message yields zeros
    fill_random(); run_hash(0, 0, 1, 0, 1, 0, 0, 1, '0);
    // R8 data then separate closing beat; R9 data-less beat mid-stream
    fill_random(); run_hash(7, 0, 1, 0, 1, 0, 0, 0, '0);
    fill_random(); run_hash(10, 1, 0, 0, 0, 0, 0, 0, '0);

    // R10 abort mid-stream, then a full hash
    fill_random(); run_hash(5, 0, 0, 0, 0, 0, 1, 0, '0);
    fill_random(); run_hash(4, 0, 0, 1, 0, 0, 0, 0, '0);
    // R10 abort while the closing beat is in flight
    fill_random(); run_hash(3, 0, 0, 0, 0, 1, 0, 0, '0);
    repeat (6) @(negedge clk);
    fill_random(); run_hash(2, 0, 0, 0, 0, 0, 0, 0, '0);

    // R11 closed after last: no acceptance, result held
    @(negedge clk);
    msg_valid_i = 1; msg_data_i = '1; key_valid_i = 1;
    #0.5;
    chk(!msg_ready_o, "R11 message refused after close", {255'd0, msg_ready_o}, '0);
    repeat (3) @(negedge clk);
    chk(res_data_o === last_res, "R11 result held", res_data_o, last_res);
    clear_inputs();
    repeat (3) @(negedge clk);

    chk(exp_q.size() == 0, "R7 every expected result delivered", 256'(exp_q.size()), '0);
    finished = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule